// File: doc/BRIEF.md
# Dual-Channel Pulse-Width Modulator

This block produces two independent pulse-width modulated outputs from a shared tick of the PWM clock. Each channel owns a range value and a data value. The range sets the period in ticks, and the data value sets how many of those ticks drive the active level. The output frequency is therefore the tick rate divided by the range. For example, a range of 1000 with data 200 gives a 20% duty cycle.

Each channel can run in one of two modes. In mark-space mode it emits one contiguous pulse per period. In balanced mode it spreads the same number of active ticks as evenly as possible across the period. Each channel also has its own enable, an output inversion bit and an idle level that is driven while the channel is off.

Software reaches the block through a simple valid/write/word-address/data port. There is one 32-bit control word holding both channels' settings and a status word with live and sticky flags. Each channel has a range word and a data word. The intended sequence for changing a channel's timing is to turn the channel off, write its range and data, and turn it back on. A write that skips the first step is rejected and flagged.

Top module: `dual_pwm`

## Requirements
- R1: After reset both outputs are 0, and the control word and status word read as 0.
- R2: All 32 bits of the control word (word address 0) are stored as written and read back unchanged, including unused and reserved bits.
- R3: Range and data words sit at word addresses 4 and 5 for channel 1, and at 8 and 9 for channel 2. Each reads back the last value accepted. Read data appears on the cycle after the read access.
- R4: In mark-space mode (control bit 7 for channel 1, bit 15 for channel 2, set to 1), an enabled channel is active for the first DAT ticks of every RNG-tick period and inactive for the rest.
- R5: In balanced mode (mark-space bit 0), an enabled channel is active for exactly DAT of every RNG consecutive ticks. When DAT is at most RNG/2, no two active ticks are adjacent.
- R6: When DAT is greater than or equal to RNG, an enabled channel stays at the active level in both modes. When DAT is 0, it stays inactive.
- R7: The inversion bit (bit 4 for channel 1, bit 12 for channel 2) inverts an enabled channel's output.
- R8: While a channel's enable bit (bit 0 for channel 1, bit 8 for channel 2) is 0, its output equals its idle-level bit (bit 3 or bit 11), and the inversion bit has no effect.
- R9: Status bit 9 reads 1 while channel 1 is enabled, and status bit 10 reads 1 while channel 2 is enabled.
- R10: A write to the range or data word of an enabled channel is dropped, and it sets status bit 8.
- R11: A write to any word other than 0, 1, 4, 5, 8 or 9 sets status bit 2. A read of such a word returns 0 and sets status bit 3.
- R12: Status bits 2, 3 and 8 stay set until a status write has a 1 in that bit position. A 0 leaves them set, and writes to the other status bits have no effect.
- R13: Counting advances only on cycles where `tick` is high, so the period in clock cycles scales with the tick spacing.
- R14: The two channels run at the same time with independent range, data and mode settings.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle PWM clock enable |
| busValid | input | 1 | Register access request this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Word address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, registered, valid the cycle after a read |
| pwmOut | output | 2 | Channel outputs, bit 0 = channel 1, bit 1 = channel 2 |

## Verification
The bench tries several duty ratios in each mode. It counts active samples over whole periods, which confirms DAT per RNG independent of phase. It also measures the longest active run, which is what separates mark-space (one run of DAT) from balanced (isolated pulses) at equal duty. The endpoints DAT=0 and DAT=RNG, inversion and idle levels are each checked with the channel on and off. A tick spaced four cycles apart shows that the period scales with the tick rather than the clock. Rejected writes, unused addresses and the write-one-to-clear rules are checked through read-backs of the range and status words.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

  localparam int NCH      = 2;
  localparam int DATA_W   = 32;

  // word addresses
  localparam int CTL_WORD   = 0;
  localparam int STA_WORD   = 1;
  localparam int RNG_BASE   = 4;
  localparam int DAT_BASE   = 5;
  localparam int CH_WSTRIDE = 4;

  // bit positions inside one channel's control byte
  localparam int CH_BSTRIDE = 8;
  localparam int EN_B  = 0;
  localparam int SIL_B = 3;
  localparam int POL_B = 4;
  localparam int MSE_B = 7;

  // status bit positions
  localparam int WERR_B   = 2;
  localparam int RERR_B   = 3;
  localparam int BERR_B   = 8;
  localparam int BUSY_B0  = 9;

  typedef struct packed {
    logic en;
    logic msen;
    logic pola;
    logic sbit;
  } chanCtl_t;

endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
  import pwm_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int CNT_W  = 32
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          busValid,
  input  logic                          busWrite,
  input  logic [ADDR_W-1:0]             busAddr,
  input  logic [DATA_W-1:0]             busWdata,
  output logic [DATA_W-1:0]             busRdata,
  output chanCtl_t [NCH-1:0]            chanCtl,
  output logic [NCH-1:0][CNT_W-1:0]     chanRng,
  output logic [NCH-1:0][CNT_W-1:0]     chanDat
);

  localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(CTL_WORD);
  localparam logic [ADDR_W-1:0] A_STA = ADDR_W'(STA_WORD);

  logic [DATA_W-1:0]         ctlQ;
  logic [NCH-1:0][CNT_W-1:0] rngQ;
  logic [NCH-1:0][CNT_W-1:0] datQ;
  logic                      wrErrQ, rdErrQ, busErrQ;

  logic wrEn, rdEn;
  logic hitCtl, hitSta, mapped;
  logic [NCH-1:0] hitRng, hitDat, chanOn;
  logic blockedWr;
  logic [DATA_W-1:0] staWord, rdMux;

  assign wrEn   = busValid &  busWrite;
  assign rdEn   = busValid & ~busWrite;
  assign hitCtl = (busAddr == A_CTL);
  assign hitSta = (busAddr == A_STA);

  always_comb begin
    mapped    = hitCtl | hitSta;
    blockedWr = 1'b0;
    for (int c = 0; c < NCH; c++) begin
      hitRng[c] = (busAddr == ADDR_W'(RNG_BASE + CH_WSTRIDE * c));
      hitDat[c] = (busAddr == ADDR_W'(DAT_BASE + CH_WSTRIDE * c));
      chanOn[c] = ctlQ[CH_BSTRIDE * c + EN_B];
      mapped    = mapped | hitRng[c] | hitDat[c];
      if (wrEn && chanOn[c] && (hitRng[c] || hitDat[c]))
        blockedWr = 1'b1;
    end
  end

  always_comb begin
    staWord = '0;
    staWord[WERR_B] = wrErrQ;
    staWord[RERR_B] = rdErrQ;
    staWord[BERR_B] = busErrQ;
    for (int c = 0; c < NCH; c++)
      staWord[BUSY_B0 + c] = chanOn[c];
  end

  always_comb begin
    rdMux = '0;
    if (hitCtl) rdMux = ctlQ;
    if (hitSta) rdMux = staWord;
    for (int c = 0; c < NCH; c++) begin
      if (hitRng[c]) rdMux = DATA_W'(rngQ[c]);
      if (hitDat[c]) rdMux = DATA_W'(datQ[c]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctlQ     <= '0;
      rngQ     <= '0;
      datQ     <= '0;
      wrErrQ   <= 1'b0;
      rdErrQ   <= 1'b0;
      busErrQ  <= 1'b0;
      busRdata <= '0;
    end else begin
      if (rdEn) busRdata <= rdMux;
      if (wrEn && hitCtl) ctlQ <= busWdata;
      for (int c = 0; c < NCH; c++) begin
        if (wrEn && hitRng[c] && !chanOn[c]) rngQ[c] <= busWdata[CNT_W-1:0];
        if (wrEn && hitDat[c] && !chanOn[c]) datQ[c] <= busWdata[CNT_W-1:0];
      end
      if (wrEn && hitSta) begin
        if (busWdata[WERR_B]) wrErrQ  <= 1'b0;
        if (busWdata[RERR_B]) rdErrQ  <= 1'b0;
        if (busWdata[BERR_B]) busErrQ <= 1'b0;
      end
      if (wrEn && !mapped) wrErrQ  <= 1'b1;
      if (rdEn && !mapped) rdErrQ  <= 1'b1;
      if (blockedWr)       busErrQ <= 1'b1;
    end
  end

  generate
    for (genvar g = 0; g < NCH; g++) begin : g_cfg
      assign chanCtl[g].en   = ctlQ[CH_BSTRIDE * g + EN_B];
      assign chanCtl[g].msen = ctlQ[CH_BSTRIDE * g + MSE_B];
      assign chanCtl[g].pola = ctlQ[CH_BSTRIDE * g + POL_B];
      assign chanCtl[g].sbit = ctlQ[CH_BSTRIDE * g + SIL_B];
      assign chanRng[g]      = rngQ[g];
      assign chanDat[g]      = datQ[g];

      // R10
      blocked_rng_chk: assert property (@(posedge clk) disable iff (!rstN)
        (wrEn && hitRng[g] && chanCtl[g].en) |=> $stable(chanRng[g]));
      // R10
      blocked_dat_chk: assert property (@(posedge clk) disable iff (!rstN)
        (wrEn && hitDat[g] && chanCtl[g].en) |=> $stable(chanDat[g]));
    end
  endgenerate

  // R12
  berr_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busErrQ && !(wrEn && hitSta && busWdata[BERR_B])) |=> busErrQ);

  // R11
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && !mapped) |=> (busRdata == '0));

  // R9
  busy_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && hitSta) |=> (busRdata[BUSY_B0 +: NCH] == $past(chanOn)));

endmodule

// File: rtl/pwm_chan.sv
module pwm_chan
  import pwm_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick,
  input  chanCtl_t         ctl,
  input  logic [CNT_W-1:0] rng,
  input  logic [CNT_W-1:0] dat,
  output logic             pwmOut
);

  logic [CNT_W-1:0] cnt, acc;
  logic [CNT_W:0]   accSum, accWrap;
  logic [CNT_W-1:0] cntInc, cntNext, accNext;
  logic             full, accHit, rawBit;

  assign full    = (dat >= rng);
  assign cntInc  = cnt + 1'b1;
  assign cntNext = (cntInc >= rng) ? '0 : cntInc;
  assign accSum  = {1'b0, acc} + {1'b0, dat};
  assign accHit  = (accSum >= {1'b0, rng});
  assign accWrap = accSum - {1'b0, rng};
  assign accNext = accHit ? accWrap[CNT_W-1:0] : accSum[CNT_W-1:0];

  always_comb begin
    if (full)          rawBit = 1'b1;
    else if (ctl.msen) rawBit = (cnt < dat);
    else               rawBit = accHit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt    <= '0;
      acc    <= '0;
      pwmOut <= 1'b0;
    end else if (!ctl.en) begin
      cnt    <= '0;
      acc    <= '0;
      pwmOut <= ctl.sbit;
    end else if (tick) begin
      cnt    <= cntNext;
      if (!full && !ctl.msen) acc <= accNext;
      pwmOut <= rawBit ^ ctl.pola;
    end
  end

  // R8
  idle_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.en |=> (pwmOut == $past(ctl.sbit)));

  // R6
  full_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.en && tick && (dat >= rng)) |=> (pwmOut == !$past(ctl.pola)));

  // R4
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.en && (rng != '0)) |-> (cnt < rng));

  // R5
  acc_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.en && !ctl.msen && (dat < rng)) |-> (acc < rng));

endmodule

// File: rtl/pwm_datapath.sv
module pwm_datapath
  import pwm_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      tick,
  input  chanCtl_t [NCH-1:0]        chanCtl,
  input  logic [NCH-1:0][CNT_W-1:0] chanRng,
  input  logic [NCH-1:0][CNT_W-1:0] chanDat,
  output logic [NCH-1:0]            pwmOut
);

  generate
    for (genvar g = 0; g < NCH; g++) begin : g_chan
      pwm_chan #(.CNT_W(CNT_W)) u_chan (
        .clk    (clk),
        .rstN   (rstN),
        .tick   (tick),
        .ctl    (chanCtl[g]),
        .rng    (chanRng[g]),
        .dat    (chanDat[g]),
        .pwmOut (pwmOut[g])
      );
    end
  endgenerate

endmodule

// File: rtl/dual_pwm.sv
module dual_pwm
  import pwm_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic [1:0]        pwmOut
);

  chanCtl_t [NCH-1:0]        chanCtl;
  logic [NCH-1:0][CNT_W-1:0] chanRng;
  logic [NCH-1:0][CNT_W-1:0] chanDat;

  pwm_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
    .clk      (clk),
    .rstN     (rstN),
    .busValid (busValid),
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .busRdata (busRdata),
    .chanCtl  (chanCtl),
    .chanRng  (chanRng),
    .chanDat  (chanDat)
  );

  pwm_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .tick    (tick),
    .chanCtl (chanCtl),
    .chanRng (chanRng),
    .chanDat (chanDat),
    .pwmOut  (pwmOut)
  );

endmodule

// File: tb/tb_dual_pwm.sv
`timescale 1ns/1ps
module tb_dual_pwm;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tick = 1'b1;
  logic        busValid = 1'b0;
  logic        busWrite = 1'b0;
  logic [3:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [1:0]  pwmOut;

  int total = 0;
  int bad = 0;
  int tickDiv = 1;
  int phase = 0;
  logic [31:0] ctlShadow = '0;

  always #5 clk = ~clk;

  dual_pwm dut (
    .clk(clk), .rstN(rstN), .tick(tick), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata), .pwmOut(pwmOut)
  );

  initial begin
    forever begin
      @(negedge clk);
      phase = (phase + 1) % tickDiv;
      tick = (phase == 0);
    end
  end

  function automatic void chk(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d (0x%0h) expected=%0d (0x%0h)", tag, act, act, exp, exp);
    end
  endfunction

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    busValid = 1'b1; busWrite = 1'b1; busAddr = 4'(a); busWdata = d;
    @(negedge clk);
    busValid = 1'b0; busWrite = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    busValid = 1'b1; busWrite = 1'b0; busAddr = 4'(a);
    @(negedge clk);
    busValid = 1'b0;
    d = busRdata;
  endtask

  task automatic setCtl(input int ch, input logic [7:0] bits);
    ctlShadow[8*ch +: 8] = bits;
    wr(0, ctlShadow);
  endtask

  // ch: 0/1, flags byte without enable; channel is turned off, loaded, turned on
  task automatic startChan(input int ch, input int rng, input int dat, input logic [7:0] flags);
    setCtl(ch, 8'h00);
    wr(4 + 4*ch, 32'(rng));
    wr(5 + 4*ch, 32'(dat));
    setCtl(ch, flags | 8'h01);
    repeat (4) @(negedge clk);
  endtask

  task automatic measure(input int ch, input int n, output int highs, output int maxRun);
    int run = 0;
    highs = 0; maxRun = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pwmOut[ch]) begin
        highs++; run++;
        if (run > maxRun) maxRun = run;
      end else run = 0;
    end
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk(pwmOut == 2'b00, "R1 outputs after reset", int'(pwmOut), 0);
    rd(0, d); chk(d == 0, "R1 control after reset", int'(d), 0);
    rd(1, d); chk(d == 0, "R1 status after reset", int'(d), 0);
  endtask

  task automatic t_ctl_rw();
    logic [31:0] d;
    wr(0, 32'hA5C3_6E00);
    rd(0, d); chk(d == 32'hA5C3_6E00, "R2 control readback", int'(d), int'(32'hA5C3_6E00));
    wr(0, 32'h0000_0000);
    rd(0, d); chk(d == 0, "R2 control cleared", int'(d), 0);
    ctlShadow = '0;
  endtask

  task automatic t_regmap();
    logic [31:0] d;
    wr(4, 32'd7); wr(5, 32'd3); wr(8, 32'd11); wr(9, 32'd9);
    rd(4, d); chk(d == 7,  "R3 rng1 readback", int'(d), 7);
    rd(5, d); chk(d == 3,  "R3 dat1 readback", int'(d), 3);
    rd(8, d); chk(d == 11, "R3 rng2 readback", int'(d), 11);
    rd(9, d); chk(d == 9,  "R3 dat2 readback", int'(d), 9);
  endtask

  task automatic t_mark();
    int h, m;
    startChan(0, 8, 2, 8'h80);
    measure(0, 16, h, m);
    chk(h == 4, "R4 mark 2/8 highs", h, 4);
    chk(m == 2, "R4 mark 2/8 run", m, 2);
    startChan(0, 10, 7, 8'h80);
    measure(0, 20, h, m);
    chk(h == 14, "R4 mark 7/10 highs", h, 14);
    chk(m == 7,  "R4 mark 7/10 run", m, 7);
    setCtl(0, 8'h00);
  endtask

  task automatic t_balanced();
    int h, m;
    startChan(0, 8, 3, 8'h00);
    measure(0, 16, h, m);
    chk(h == 6, "R5 balanced 3/8 highs", h, 6);
    chk(m == 1, "R5 balanced 3/8 run", m, 1);
    startChan(0, 8, 4, 8'h00);
    measure(0, 16, h, m);
    chk(h == 8, "R5 balanced 4/8 highs", h, 8);
    chk(m == 1, "R5 balanced 4/8 run", m, 1);
    setCtl(0, 8'h00);
  endtask

  task automatic t_limits();
    int h, m;
    startChan(0, 8, 8, 8'h80);
    measure(0, 16, h, m); chk(h == 16, "R6 dat=rng mark constant high", h, 16);
    startChan(0, 8, 12, 8'h00);
    measure(0, 16, h, m); chk(h == 16, "R6 dat>rng balanced constant high", h, 16);
    startChan(0, 8, 0, 8'h80);
    measure(0, 16, h, m); chk(h == 0, "R6 dat=0 constant low", h, 0);
    setCtl(0, 8'h00);
  endtask

  task automatic t_polarity();
    int h, m;
    startChan(1, 8, 2, 8'h90);
    measure(1, 16, h, m);
    chk(h == 12, "R7 inverted 2/8 highs", h, 12);
    chk(m == 6,  "R7 inverted 2/8 run", m, 6);
    setCtl(1, 8'h00);
  endtask

  task automatic t_silence();
    int h, m;
    setCtl(0, 8'h18);
    repeat (3) @(negedge clk);
    measure(0, 12, h, m); chk(h == 12, "R8 idle level 1 ignores inversion", h, 12);
    setCtl(0, 8'h10);
    repeat (3) @(negedge clk);
    measure(0, 12, h, m); chk(h == 0, "R8 idle level 0 ignores inversion", h, 0);
    setCtl(1, 8'h08);
    repeat (3) @(negedge clk);
    chk(pwmOut[1] == 1'b1, "R8 ch2 idle level 1", int'(pwmOut[1]), 1);
    setCtl(1, 8'h00);
    setCtl(0, 8'h00);
  endtask

  task automatic t_status_indep();
    logic [31:0] d;
    int h, m;
    startChan(0, 8, 2, 8'h80);
    startChan(1, 8, 6, 8'h80);
    rd(1, d); chk(d[10:9] == 2'b11, "R9 both busy bits", int'(d[10:9]), 3);
    measure(0, 16, h, m); chk(h == 4,  "R14 ch1 while ch2 runs", h, 4);
    measure(1, 16, h, m); chk(h == 12, "R14 ch2 while ch1 runs", h, 12);
    setCtl(1, 8'h00);
    rd(1, d); chk(d[10:9] == 2'b01, "R9 only ch1 busy", int'(d[10:9]), 1);
    setCtl(0, 8'h00);
    rd(1, d); chk(d[10:9] == 2'b00, "R9 none busy", int'(d[10:9]), 0);
  endtask

  task automatic t_buserr();
    logic [31:0] d;
    startChan(0, 8, 2, 8'h80);
    wr(4, 32'd99);
    wr(5, 32'd77);
    rd(4, d); chk(d == 8, "R10 rng1 write dropped", int'(d), 8);
    rd(5, d); chk(d == 2, "R10 dat1 write dropped", int'(d), 2);
    rd(1, d); chk(d[8] == 1'b1, "R10 bus error flagged", int'(d[8]), 1);
    wr(1, 32'hFFFF_FEFF);
    rd(1, d); chk(d[8] == 1'b1, "R12 zero in bit 8 keeps flag", int'(d[8]), 1);
    chk(d[9] == 1'b1, "R12 busy bit not writable", int'(d[9]), 1);
    wr(1, 32'h0000_0100);
    rd(1, d); chk(d[8] == 1'b0, "R12 one in bit 8 clears flag", int'(d[8]), 0);
    setCtl(0, 8'h00);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    wr(3, 32'hFFFF_FFFF);
    rd(1, d); chk(d[2] == 1'b1, "R11 write to unused sets bit 2", int'(d[2]), 1);
    rd(7, d); chk(d == 0, "R11 unused read returns zero", int'(d), 0);
    rd(1, d); chk(d[3] == 1'b1, "R11 unused read sets bit 3", int'(d[3]), 1);
    wr(1, 32'h0000_0004);
    rd(1, d);
    chk(d[2] == 1'b0, "R12 bit 2 cleared", int'(d[2]), 0);
    chk(d[3] == 1'b1, "R12 bit 3 kept", int'(d[3]), 1);
    wr(1, 32'h0000_0008);
    rd(1, d); chk(d == 0, "R12 status clear", int'(d), 0);
  endtask

  task automatic t_tick();
    int h, m;
    tickDiv = 4;
    startChan(0, 5, 2, 8'h80);
    measure(0, 40, h, m);
    chk(h == 16, "R13 divided tick highs", h, 16);
    chk(m == 8,  "R13 divided tick run", m, 8);
    setCtl(0, 8'h00);
    tickDiv = 1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_ctl_rw();
    t_regmap();
    t_mark();
    t_balanced();
    t_limits();
    t_polarity();
    t_silence();
    t_status_indep();
    t_buserr();
    t_unmapped();
    t_tick();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule